// File: doc/BRIEF.md
# Multi-Channel FIFO Bus Master

This block is the master end of a synchronous FIFO bus that carries several logical channels over one shared 32-bit data path. The slave device supplies the bus clock, and the whole block runs on it. While the bus is idle, the master drives the outer data bytes and the byte-enable lines high and releases byte lane 1. The slave uses that lane to report, active low, which channels are ready. A user request names a channel, a direction and a word count. It is accepted only when the sampled status shows that channel ready in the requested direction.

A transaction starts with a command cycle. In that cycle the master pulls its request line low, puts the one-based channel number on the low data byte and puts a direction code on the byte enables. A released turnaround cycle follows, and then the data phase. During the data phase, each clock in which the slave's acknowledge is low moves one word. On a read, the word is captured into a holding register. On a write, the word is taken from the user's first-word-fall-through stream.

The transaction ends in one of three ways: the word count is reached, the slave withdraws its acknowledge, or no acknowledge arrives within a run-time limit. In each case a released tail cycle is inserted before the bus returns to idle driving.

Top module: `mfb_master`

## Requirements
- R1: In idle and after reset, `wr_n` is 1 and `be_o`=4'hF with `be_oe`=1. `data_oe`=4'b1101, so byte lane 1 (bits 15:8) is released, and `data_o[31:16]` and `data_o[7:0]` are all ones.
- R2: `stat_o` takes `data_i[15:8]` at each clock edge that ends an idle cycle. `stat_o[3:0]` holds IN channels 1..4 from bits 11:8, and `stat_o[7:4]` holds OUT channels 1..4 from bits 15:12. Bus status at any other time is ignored: `stat_o` holds from the command cycle through the tail cycle. Its reset value is 8'hFF.
- R3: `req_ready` is 1 only in idle, and only when the status bit for the request is 0. A write to channel n uses `stat_o[n-1]`; a read from channel n uses `stat_o[4+n-1]`. `req_chan` is zero-based. While `req_ready` is 0, `wr_n` stays 1.
- R4: The cycle after acceptance is the command cycle. In it, `wr_n`=0, all lanes and the byte enables are driven, `data_o[7:0]`=`req_chan`+1, and `be_o`=4'h0 for a read or 4'h1 for a write.
- R5: The cycle after the command cycle is a turnaround. `wr_n` stays 0, and `data_oe`=0 and `be_oe`=0.
- R6: On a read, every data-phase clock edge with `rxf_n`=0 captures `data_i`. `rd_valid`=1 with that word on `rd_data` during the next cycle.
- R7: On a write, during data-phase cycles with `rxf_n`=0, `wr_take`=1, all lanes are driven, `be_o`=4'hF and `data_o`=`wr_data`.
- R8: After `req_len`+1 words, the next cycle is the tail cycle. In it, `wr_n`=1, `data_oe`=0, `be_oe`=0 and `done_o`=1. The cycle after that is idle.
- R9: If `rxf_n` is sampled high in the data phase after at least one word has moved, the transaction ends early through the same tail cycle with `done_o`=1.
- R10: If `rxf_n` is sampled high at `tmo_limit` consecutive data-phase edges before any word has moved, the block enters the tail cycle with `err_o`=1 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the slave |
| rst | input | 1 | Synchronous active-high reset |
| tmo_limit | input | 12 | Acknowledge timeout in clocks |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_chan | input | 2 | Zero-based channel index |
| req_write | input | 1 | 1 = master write, 0 = master read |
| req_len | input | 8 | Word count minus one |
| wr_data | input | 32 | Head of the user write stream |
| wr_take | output | 1 | Write word consumed at this edge |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| done_o | output | 1 | Tail cycle of a completed transfer |
| err_o | output | 1 | Tail cycle of a timed-out transfer |
| stat_o | output | 8 | Sampled channel status, active low |
| wr_n | output | 1 | Active-low transaction request |
| rxf_n | input | 1 | Active-low slave acknowledge |
| data_i | input | 32 | Data bus as seen at the pads |
| data_o | output | 32 | Data bus value driven by the master |
| data_oe | output | 4 | Per-byte-lane output enable |
| be_o | output | 4 | Byte-enable / command code value |
| be_oe | output | 1 | Byte-enable output enable |

## Verification
The bench offers requests whose channel is not ready, including one where the opposite-direction bit is ready. A design that decoded the wrong nibble would start a transaction the slave cannot serve. It changes the status lane in the middle of a transfer and checks that the latched status is unchanged at the tail. A block that kept sampling would start later requests from bus data taken as status. It runs acknowledge gaps before the first word, an acknowledge withdrawn before the count, single-word transfers and an acknowledge that never comes. A wrong end condition would show up as an extra or missing word, a missing tail release or a hung request line.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_CMD,
        BUS_TURN,
        BUS_XFER,
        BUS_TAIL
    } bus_st_t;

    localparam logic [3:0] CODE_RD = 4'h0;
    localparam logic [3:0] CODE_WR = 4'h1;

    typedef struct packed {
        logic       write;
        logic [7:0] chan;   // zero-based channel index
    } txn_t;

    function automatic logic [3:0] cmd_code(input logic write);
        return write ? CODE_WR : CODE_RD;
    endfunction

    // position of a channel's ready bit inside the sampled status byte
    function automatic int unsigned stat_index(input logic write,
                                               input int unsigned chan,
                                               input int unsigned nch);
        return write ? chan : nch + chan;
    endfunction

endpackage

// File: rtl/mfb_status_reg.sv
module mfb_status_reg #(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [2*NCH-1:0] bus_stat,
    output logic [2*NCH-1:0] stat_q
);
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '1;
        else if (sample_en)
            stat_q <= bus_stat;
    end
endmodule

// File: rtl/mfb_word_ctr.sv
module mfb_word_ctr #(
    parameter int LEN_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             beat,
    input  logic             wait_tick,
    input  logic [LEN_W-1:0] last_len,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             last_o,
    output logic             tmo_o,
    output logic             any_o
);
    logic [LEN_W-1:0] beats;
    logic [TMO_W-1:0] waits;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beats <= '0;
            waits <= '0;
            seen  <= 1'b0;
        end else begin
            if (beat) begin
                beats <= beats + 1'b1;
                seen  <= 1'b1;
            end
            if (wait_tick)
                waits <= waits + 1'b1;
        end
    end

    assign last_o = (beats == last_len);
    assign tmo_o  = ({1'b0, waits} + 1'b1) >= {1'b0, tmo_limit};
    assign any_o  = seen;
endmodule

// File: rtl/mfb_lane_mux.sv
module mfb_lane_mux
    import mfb_pkg::*;
#(
    parameter int DW      = 32,
    parameter int STAT_LN = 1
) (
    input  bus_st_t        st,
    input  txn_t           txn,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  data_o,
    output logic [DW/8-1:0] data_oe,
    output logic [3:0]     be_o,
    output logic           be_oe
);
    localparam int LANES = DW / 8;

    logic [LANES-1:0] idle_oe;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign idle_oe[g] = (g != STAT_LN);
    end

    always_comb begin
        data_o  = '1;
        data_oe = idle_oe;
        be_o    = 4'hF;
        be_oe   = 1'b1;
        unique case (st)
            BUS_CMD: begin
                data_o[7:0] = txn.chan + 8'd1;
                data_oe     = '1;
                be_o        = cmd_code(txn.write);
            end
            BUS_TURN, BUS_TAIL: begin
                data_oe = '0;
                be_oe   = 1'b0;
            end
            BUS_XFER: begin
                if (txn.write) begin
                    data_o  = wr_data;
                    data_oe = '1;
                end else begin
                    data_oe = '0;
                    be_oe   = 1'b0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mfb_master.sv
module mfb_master
    import mfb_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NCH   = 4,
    parameter int LEN_W = 8,
    parameter int TMO_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TMO_W-1:0]       tmo_limit,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [$clog2(NCH)-1:0] req_chan,
    input  logic                   req_write,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [DW-1:0]          wr_data,
    output logic                   wr_take,
    output logic [DW-1:0]          rd_data,
    output logic                   rd_valid,
    output logic                   done_o,
    output logic                   err_o,
    output logic [2*NCH-1:0]       stat_o,
    output logic                   wr_n,
    input  logic                   rxf_n,
    input  logic [DW-1:0]          data_i,
    output logic [DW-1:0]          data_o,
    output logic [DW/8-1:0]        data_oe,
    output logic [3:0]             be_o,
    output logic                   be_oe
);
    localparam int STAT_LSB = 8;
    localparam int STAT_LN  = STAT_LSB / 8;

    bus_st_t          st, st_nx;
    txn_t             txn;
    logic [LEN_W-1:0] len_q;
    logic             end_err, end_err_nx;
    logic             accept, beat, wait_tick;
    logic             last, tmo, any;

    mfb_status_reg #(.NCH(NCH)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .sample_en (st == BUS_IDLE),
        .bus_stat  (data_i[STAT_LSB +: 2*NCH]),
        .stat_q    (stat_o)
    );

    assign req_ready = (st == BUS_IDLE) &&
                       !stat_o[stat_index(req_write, int'(req_chan), NCH)];
    assign accept    = req_valid && req_ready;
    assign beat      = (st == BUS_XFER) && !rxf_n;
    assign wait_tick = (st == BUS_XFER) && rxf_n && !any;

    mfb_word_ctr #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .clear     (st != BUS_XFER),
        .beat      (beat),
        .wait_tick (wait_tick),
        .last_len  (len_q),
        .tmo_limit (tmo_limit),
        .last_o    (last),
        .tmo_o     (tmo),
        .any_o     (any)
    );

    always_comb begin
        st_nx      = st;
        end_err_nx = end_err;
        unique case (st)
            BUS_IDLE: if (accept) st_nx = BUS_CMD;
            BUS_CMD:  st_nx = BUS_TURN;
            BUS_TURN: st_nx = BUS_XFER;
            BUS_XFER: begin
                if (beat && last) begin
                    st_nx      = BUS_TAIL;
                    end_err_nx = 1'b0;
                end else if (rxf_n && any) begin
                    st_nx      = BUS_TAIL;
                    end_err_nx = 1'b0;
                end else if (wait_tick && tmo) begin
                    st_nx      = BUS_TAIL;
                    end_err_nx = 1'b1;
                end
            end
            BUS_TAIL: st_nx = BUS_IDLE;
            default:  st_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BUS_IDLE;
            txn      <= '0;
            len_q    <= '0;
            end_err  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st       <= st_nx;
            end_err  <= end_err_nx;
            rd_valid <= beat && !txn.write;
            if (beat && !txn.write)
                rd_data <= data_i;
            if (accept) begin
                txn.write <= req_write;
                txn.chan  <= 8'(req_chan);
                len_q     <= req_len;
            end
        end
    end

    assign wr_take = beat && txn.write;
    assign wr_n    = !((st == BUS_CMD) || (st == BUS_TURN) || (st == BUS_XFER));
    assign done_o  = (st == BUS_TAIL) && !end_err;
    assign err_o   = (st == BUS_TAIL) && end_err;

    mfb_lane_mux #(.DW(DW), .STAT_LN(STAT_LN)) u_mux (
        .st      (st),
        .txn     (txn),
        .wr_data (wr_data),
        .data_o  (data_o),
        .data_oe (data_oe),
        .be_o    (be_o),
        .be_oe   (be_oe)
    );
endmodule

// File: rtl/mfb_master_chk.sv
module mfb_master_chk #(
    parameter int DW  = 32,
    parameter int NCH = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_ready,
    input logic [$clog2(NCH)-1:0] req_chan,
    input logic                   req_write,
    input logic [DW-1:0]          wr_data,
    input logic                   wr_take,
    input logic                   rd_valid,
    input logic                   done_o,
    input logic                   err_o,
    input logic [2*NCH-1:0]       stat_o,
    input logic                   wr_n,
    input logic                   rxf_n,
    input logic [DW-1:0]          data_o,
    input logic [DW/8-1:0]        data_oe,
    input logic [3:0]             be_o,
    input logic                   be_oe
);
    localparam int LANES = DW / 8;
    localparam logic [LANES-1:0] IDLE_OE = ~(LANES'(1) << 1);

    a_r3_ready_needs_status: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (wr_n && !stat_o[req_write ? int'(req_chan) : NCH + int'(req_chan)]));

    a_r4_command_word: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> (data_oe == '1 && be_oe && data_o[7:0] >= 8'd1 &&
                         data_o[7:0] <= 8'(NCH) && be_o[3:1] == 3'b000));

    a_r5_turn_release: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |=> (!wr_n && data_oe == '0 && !be_oe));

    a_r2_status_frozen: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> $stable(stat_o));

    a_r6_read_follows_ack: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!rxf_n && !wr_n));

    a_r7_write_drive: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (!wr_n && !rxf_n && data_oe == '1 && be_o == 4'hF && data_o == wr_data));

    a_r8_tail_release: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (data_oe == '0 && !be_oe && (done_o || err_o)));

    a_r1_idle_after_tail: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |=> (wr_n && data_oe == IDLE_OE && be_oe && be_o == 4'hF));

    a_r10_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o}));
endmodule

bind mfb_master mfb_master_chk #(.DW(DW), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .req_write (req_write),
    .wr_data   (wr_data),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .done_o    (done_o),
    .err_o     (err_o),
    .stat_o    (stat_o),
    .wr_n      (wr_n),
    .rxf_n     (rxf_n),
    .data_o    (data_o),
    .data_oe   (data_oe),
    .be_o      (be_o),
    .be_oe     (be_oe)
);

// File: tb/mfb_master_test.sv
`timescale 1ns/1ps
module mfb_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] tmo_limit = 12'd6;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_chan = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_len = '0;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic [31:0] rd_data;
    logic        rd_valid, done_o, err_o;
    logic [7:0]  stat_o;
    logic        wr_n;
    logic        rxf_n = 1'b1;
    logic [31:0] data_i = '1;
    logic [31:0] data_o;
    logic [3:0]  data_oe;
    logic [3:0]  be_o;
    logic        be_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mfb_master uut (.*);

    // {write, chan, len-1, ack delay, words the slave gives (0 = none)}
    localparam int NV = 7;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 2'd0, 4'd0, 3'd0, 4'd1},
        {1'b1, 2'd1, 4'd3, 3'd0, 4'd4},
        {1'b0, 2'd3, 4'd2, 3'd2, 4'd3},
        {1'b1, 2'd3, 4'd0, 3'd1, 4'd1},
        {1'b0, 2'd2, 4'd5, 3'd0, 4'd2},
        {1'b1, 2'd0, 4'd4, 3'd3, 4'd3},
        {1'b0, 2'd1, 4'd2, 3'd0, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        check(req, {31'd0, wr_n}, 32'd1);
        check(req, {28'd0, data_oe}, 32'hD);
        check(req, {27'd0, be_oe, be_o}, 32'h1F);
        check(req, {data_o[31:16], data_o[7:0], 8'h00}, 32'hFFFF_FF00);
    endtask

    task automatic run_txn(input logic wr, input logic [1:0] ch, input logic [3:0] lm1,
                           input logic [2:0] dly, input logic [3:0] give);
        logic [7:0] st_exp;
        int nlen, nexp, guard;
        logic [31:0] w;
        nlen = int'(lm1) + 1;
        nexp = (int'(give) < nlen) ? int'(give) : nlen;
        data_i = '1;
        if (wr) data_i[8 + ch] = 1'b0; else data_i[12 + ch] = 1'b0;
        req_chan = ch; req_write = wr; req_len = 8'(lm1); req_valid = 1'b1; rxf_n = 1'b1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!req_ready && guard < 10);
        check("R3 ready on status", {31'd0, req_ready}, 32'd1);
        @(negedge clk);                                  // command cycle
        req_valid = 1'b0;
        st_exp = stat_o;
        data_i[15:8] = 8'h00;                            // status noise, must be ignored
        check("R4 wr_n low", {31'd0, wr_n}, 32'd0);
        check("R4 channel", {24'd0, data_o[7:0]}, 32'(ch) + 1);
        check("R4 code", {27'd0, be_oe, be_o}, {27'd0, 1'b1, 3'b000, wr});
        check("R4 lanes", {28'd0, data_oe}, 32'hF);
        @(negedge clk);                                  // turnaround
        check("R5 turnaround", {26'd0, wr_n, be_oe, data_oe}, 32'd0);
        @(negedge clk);                                  // data phase
        if (give == 0) begin
            rxf_n = 1'b1;
            for (int k = 0; k < int'(tmo_limit); k++) begin
                check("R10 waiting", {31'd0, wr_n}, 32'd0);
                @(negedge clk);
            end
            check("R10 err", {30'd0, err_o, done_o}, 32'd2);
            check("R10 release", {26'd0, wr_n, be_oe, data_oe}, 32'h20);
        end else begin
            for (int k = 0; k < int'(dly); k++) begin
                rxf_n = 1'b1;
                @(negedge clk);
            end
            for (int k = 0; k < nexp; k++) begin
                w = {8'hC0 + 8'(ch), 8'(k), 8'h5A ^ 8'(k), 8'h3C + 8'(lm1)};
                rxf_n = 1'b0;
                if (wr) begin
                    wr_data = w;
                    #1;
                    check("R7 take", {31'd0, wr_take}, 32'd1);
                    check("R7 data", data_o, w);
                    check("R7 be", {27'd0, be_oe, be_o}, 32'h1F);
                end else begin
                    data_i = w;
                end
                @(negedge clk);
                if (!wr) begin
                    check("R6 valid", {31'd0, rd_valid}, 32'd1);
                    check("R6 data", rd_data, w);
                end
            end
            rxf_n = 1'b1;
            if (nexp < nlen) begin
                check("R9 still open", {31'd0, wr_n}, 32'd0);
                @(negedge clk);
                check("R9 early done", {30'd0, err_o, done_o}, 32'd1);
            end else begin
                check("R8 done", {30'd0, err_o, done_o}, 32'd1);
            end
            check("R8 tail release", {26'd0, wr_n, be_oe, data_oe}, 32'h20);
        end
        check("R2 status held", {24'd0, stat_o}, {24'd0, st_exp});
        rxf_n = 1'b1;
        data_i = '1;
        @(negedge clk);
        idle_check("R1 idle after tail");
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1 reset");
        check("R2 reset status", {24'd0, stat_o}, 32'hFF);
        check("R3 reset ready", {31'd0, req_ready}, 32'd0);

        // R2 status sampling in idle
        data_i[15:8] = 8'hA5;
        @(negedge clk);
        check("R2 sample", {24'd0, stat_o}, 32'hA5);
        data_i = '1;
        @(negedge clk);

        // R3 not ready: only the opposite direction bit is low
        data_i[8] = 1'b0;
        req_chan = 2'd0; req_write = 1'b0; req_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R3 wrong nibble", {30'd0, req_ready, wr_n}, 32'd1);
        end
        req_valid = 1'b0;
        data_i = '1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][13], VEC[i][12:11], VEC[i][10:7], VEC[i][6:4], VEC[i][3:0]);
        end

        // timeout with a limit of one
        tmo_limit = 12'd1;
        run_txn(1'b1, 2'd2, 4'd1, 3'd0, 4'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule